// File: doc/BRIEF.md
# I/O Write Snoop Capture Buffer

This block listens passively to a target processor's 8-bit data bus. Every time the target fires its I/O chip-select strobe, the byte on the bus is taken into a local circular store of `DEPTH` entries (default 256, a power of two). The strobe and the bus are asynchronous to the local clock. Both pass through the same synchroniser chain, so each byte stays aligned with its strobe edge. The write position simply wraps. No full condition is kept: once `DEPTH` bytes are stored without a read, the write position catches up with the read position and the store reads as empty.

A local consumer removes bytes with a one-cycle pop request. Each request gets a response one cycle later. The response carries the byte, or an invalid flag when nothing was waiting. So that the target can see how much room it has, the block reports its read position back into target memory over a simple request/acknowledge memory port. The word just below the configured remote base address (base minus 1) holds that consumer index, and base minus 2 holds the target's producer index. Loading a new base starts a short start-up sequence: the producer index is read and copied into the consumer index, and then the base becomes active. Loading zero turns reporting off.

Top module: `iowr_snoop_ring`

## Requirements
- R1: After a synchronous reset, `avail_o`, `rsp_o`, `rsp_valid_o` and `mem_req_o` are 0. The read position, the write position and the active base are all zero.
- R2: Each rising edge of `io_strobe_i` stores the `bus_data_i` value present with that edge. Bytes are popped in the order they were stored. A byte becomes visible on `avail_o` three clock edges after the strobe is first sampled high.
- R3: `avail_o` is 1 exactly when the 8-bit write and read positions differ. It never rises without a capture. After `DEPTH` captures with no pop it reads 0 again, and the next capture overwrites the slot at the read position.
- R4: Every cycle with `pop_i` high gives `rsp_o`=1 on the following cycle, and `rsp_o` is 0 otherwise. The response has `rsp_valid_o`=1 with the oldest byte if `avail_o` was 1. Otherwise `rsp_valid_o`=0, `rsp_data_o`=0 and the read position is unchanged.
- R5: The read position wraps from `DEPTH`-1 to 0, and the value 0 is what gets reported.
- R6: After a valid pop with a nonzero active base, a memory write (`mem_we_o`=1) of the current read position to base minus 1 is issued. Pops that arrive while a report is outstanding are merged, and one further write then carries the latest position.
- R7: While the active base is zero, pops cause no memory request.
- R8: Loading a nonzero base (`base_load_i` pulse with `base_addr_i`) first issues a read of base minus 2. It then writes the returned byte to base minus 1, and only after that makes the new base active. Loading zero clears the active base with no memory request.
- R9: Once `mem_req_o` is raised, it stays high with stable `mem_we_o`, `mem_addr_o` and `mem_wdata_o` until a cycle with `mem_ack_i`=1. A read returns its data on `mem_rdata_i` in that acknowledge cycle.
- R10: A capture and a pop can fall on the same clock edge, and both take effect. The pop decides on the state before the capture, so with an empty store it returns invalid and leaves the new byte available.
- R11: A strobe held high captures once, and its falling edge captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe_i | input | 1 | Asynchronous I/O chip-select strobe of the target |
| bus_data_i | input | 8 | Target data bus, asynchronous |
| pop_i | input | 1 | Consumer pop request, one per cycle |
| avail_o | output | 1 | At least one byte is waiting |
| rsp_o | output | 1 | Response to the pop of the previous cycle |
| rsp_valid_o | output | 1 | Response carries a byte |
| rsp_data_o | output | 8 | Popped byte, 0 when invalid |
| base_load_i | input | 1 | Load `base_addr_i` as new remote base |
| base_addr_i | input | ADDR_W | Remote base address, 0 disables reporting |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Target memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 8 | Read data, valid with `mem_ack_i` |

## Verification
Two pairs of functions can share a cycle. The first is a strobe capture and a pop. The bench raises the strobe two edges before a pop, so that both land on the same edge, once with an empty store and once with one byte waiting. It judges the response and `avail_o` against a behavioural model that always lets the pop see the state before the capture. The second is a pop and the issue of a pending report. The bench sends three pops back to back while the memory answers slowly. It expects exactly two writes, with the last one carrying the final read position.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    localparam int BYTE_W        = 8;
    localparam int PROD_IDX_BACK = 2;   // producer index sits two below base
    localparam int CONS_IDX_BACK = 1;   // consumer index sits one below base

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        IW_IDLE   = 2'd0,
        IW_FETCH  = 2'd1,
        IW_COPY   = 2'd2,
        IW_REPORT = 2'd3
    } iw_state_e;

    typedef struct packed {
        logic  strobe;
        logic  valid;
        byte_t data;
    } pop_rsp_t;
endpackage

// File: rtl/snoop_strobe_sync.sv
module snoop_strobe_sync
    import snoop_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter bit CAPTURE_ON_RISE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe_i,
    input  byte_t data_i,
    output logic  cap_o,
    output byte_t cap_data_o
);
    // st_q[SYNC_STAGES-1] is the last synchronised stage, st_q[SYNC_STAGES] its history
    logic [SYNC_STAGES:0] st_q;
    byte_t                dat_q [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            for (int i = 0; i < SYNC_STAGES; i++) dat_q[i] <= '0;
        end else begin
            st_q     <= {st_q[SYNC_STAGES-1:0], strobe_i};
            dat_q[0] <= data_i;
            for (int i = 1; i < SYNC_STAGES; i++) dat_q[i] <= dat_q[i-1];
        end
    end

    generate
        if (CAPTURE_ON_RISE) begin : g_rise
            assign cap_o = st_q[SYNC_STAGES-1] & ~st_q[SYNC_STAGES];
        end else begin : g_fall
            assign cap_o = ~st_q[SYNC_STAGES-1] & st_q[SYNC_STAGES];
        end
    endgenerate

    assign cap_data_o = dat_q[SYNC_STAGES-1];
endmodule

// File: rtl/snoop_ring.sv
module snoop_ring
    import snoop_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  byte_t            wr_data_i,
    input  logic             pop_i,
    output logic             avail_o,
    output logic             pop_taken_o,
    output pop_rsp_t         rsp_o,
    output logic [PTR_W-1:0] rd_ptr_o
);
    byte_t            store_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    pop_rsp_t         rsp_q;

    assign avail_o     = (wr_q != rd_q);
    assign pop_taken_o = pop_i & avail_o;

    always_ff @(posedge clk) begin
        if (wr_en_i) store_q[wr_q] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            rsp_q <= '0;
        end else begin
            if (wr_en_i) wr_q <= wr_q + 1'b1;
            rsp_q.strobe <= pop_i;
            rsp_q.valid  <= pop_taken_o;
            rsp_q.data   <= pop_taken_o ? store_q[rd_q] : '0;
            if (pop_taken_o) rd_q <= rd_q + 1'b1;
        end
    end

    assign rsp_o    = rsp_q;
    assign rd_ptr_o = rd_q;
endmodule

// File: rtl/snoop_index_writer.sv
module snoop_index_writer
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_base_i,
    input  logic              pop_taken_i,
    input  logic [PTR_W-1:0]  rd_ptr_i,
    input  logic              mem_ack_i,
    input  byte_t             mem_rdata_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output byte_t             mem_wdata_o
);
    localparam logic [ADDR_W-1:0] PROD_BACK = ADDR_W'(PROD_IDX_BACK);
    localparam logic [ADDR_W-1:0] CONS_BACK = ADDR_W'(CONS_IDX_BACK);

    iw_state_e         st_q;
    logic [ADDR_W-1:0] cand_q;
    logic [ADDR_W-1:0] op_base_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;
    byte_t             wdata_q;
    logic              init_pend_q;
    logic              wb_pend_q;
    logic              base_zero;
    logic              issue_wb;

    assign base_zero = (base_q == '0);
    assign issue_wb  = (st_q == IW_IDLE) && !init_pend_q && wb_pend_q && !base_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= IW_IDLE;
            cand_q      <= '0;
            op_base_q   <= '0;
            base_q      <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            init_pend_q <= 1'b0;
            wb_pend_q   <= 1'b0;
        end else begin
            if (load_i) cand_q <= load_base_i;
            init_pend_q <= load_i | (init_pend_q & (st_q != IW_IDLE));
            wb_pend_q   <= (pop_taken_i & !base_zero) | (wb_pend_q & !issue_wb & !base_zero);
            case (st_q)
                IW_IDLE: begin
                    if (init_pend_q) begin
                        if (cand_q == '0) begin
                            base_q <= '0;
                        end else begin
                            op_base_q <= cand_q;
                            addr_q    <= cand_q - PROD_BACK;
                            st_q      <= IW_FETCH;
                        end
                    end else if (issue_wb) begin
                        addr_q  <= base_q - CONS_BACK;
                        wdata_q <= BYTE_W'(rd_ptr_i);
                        st_q    <= IW_REPORT;
                    end
                end
                IW_FETCH: if (mem_ack_i) begin
                    addr_q  <= op_base_q - CONS_BACK;
                    wdata_q <= mem_rdata_i;
                    st_q    <= IW_COPY;
                end
                IW_COPY: if (mem_ack_i) begin
                    base_q <= op_base_q;
                    st_q   <= IW_IDLE;
                end
                IW_REPORT: if (mem_ack_i) st_q <= IW_IDLE;
                default: st_q <= IW_IDLE;
            endcase
        end
    end

    assign mem_req_o   = (st_q != IW_IDLE);
    assign mem_we_o    = (st_q == IW_COPY) || (st_q == IW_REPORT);
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/iowr_snoop_ring.sv
module iowr_snoop_ring
    import snoop_pkg::*;
#(
    parameter int DEPTH           = 256,
    parameter int ADDR_W          = 16,
    parameter int SYNC_STAGES     = 2,
    parameter bit CAPTURE_ON_RISE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_strobe_i,
    input  logic [7:0]        bus_data_i,
    input  logic              pop_i,
    output logic              avail_o,
    output logic              rsp_o,
    output logic              rsp_valid_o,
    output logic [7:0]        rsp_data_o,
    input  logic              base_load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_rdata_i
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             cap_pulse;
    byte_t            cap_data;
    logic             pop_taken;
    logic [PTR_W-1:0] rd_ptr;
    pop_rsp_t         rsp;

    snoop_strobe_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .CAPTURE_ON_RISE(CAPTURE_ON_RISE)
    ) u_sync (
        .clk(clk), .rst(rst),
        .strobe_i(io_strobe_i), .data_i(bus_data_i),
        .cap_o(cap_pulse), .cap_data_o(cap_data)
    );

    snoop_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst),
        .wr_en_i(cap_pulse), .wr_data_i(cap_data),
        .pop_i(pop_i), .avail_o(avail_o), .pop_taken_o(pop_taken),
        .rsp_o(rsp), .rd_ptr_o(rd_ptr)
    );

    snoop_index_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_writer (
        .clk(clk), .rst(rst),
        .load_i(base_load_i), .load_base_i(base_addr_i),
        .pop_taken_i(pop_taken), .rd_ptr_i(rd_ptr),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    assign rsp_o       = rsp.strobe;
    assign rsp_valid_o = rsp.valid;
    assign rsp_data_o  = rsp.data;
endmodule

// File: rtl/iowr_snoop_ring_chk.sv
module iowr_snoop_ring_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pop_i,
    input logic              avail_o,
    input logic              rsp_o,
    input logic              rsp_valid_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_wdata_o,
    input logic              mem_ack_i,
    input logic              cap_pulse
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o)
                                       && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    p_rsp_every_pop_r4: assert property (@(posedge clk) disable iff (rst)
        pop_i |=> rsp_o);

    p_rsp_only_pop_r4: assert property (@(posedge clk) disable iff (rst)
        !pop_i |=> !rsp_o);

    p_empty_pop_invalid_r4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !avail_o) |=> !rsp_valid_o);

    p_data_pop_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && avail_o) |=> rsp_valid_o);

    p_no_spontaneous_data_r3: assert property (@(posedge clk) disable iff (rst)
        (!avail_o && !cap_pulse) |=> !avail_o);

    p_single_capture_r11: assert property (@(posedge clk) disable iff (rst)
        cap_pulse |=> !cap_pulse);
endmodule

bind iowr_snoop_ring iowr_snoop_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .pop_i(pop_i), .avail_o(avail_o),
    .rsp_o(rsp_o), .rsp_valid_o(rsp_valid_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .cap_pulse(cap_pulse)
);

// File: tb/iowr_snoop_ring_test.sv
module iowr_snoop_ring_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int MEM_LAT    = 3;
    localparam logic [AW-1:0] BASE = 16'h1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b0;
    logic [7:0]    bus_data = '0;
    logic          pop = 1'b0;
    logic          base_load = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic          avail_o, rsp_o, rsp_valid_o, mem_req_o, mem_we_o;
    logic [7:0]    rsp_data_o, mem_wdata_o;
    logic [AW-1:0] mem_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iowr_snoop_ring #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .io_strobe_i(strobe), .bus_data_i(bus_data),
        .pop_i(pop), .avail_o(avail_o), .rsp_o(rsp_o), .rsp_valid_o(rsp_valid_o),
        .rsp_data_o(rsp_data_o), .base_load_i(base_load), .base_addr_i(base_addr),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_wc = '0, m_rc = '0;
    logic [7:0] m_ring [256];
    logic       s_k1 = 0, s_k2 = 0, s_k3 = 0;
    logic [7:0] d_k1 = '0, d_k2 = '0;
    logic       e_rsp = 0, e_valid = 0;
    logic [7:0] e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_wc = '0; m_rc = '0; s_k1 = 0; s_k2 = 0; s_k3 = 0;
            d_k1 = '0; d_k2 = '0; e_rsp = 0; e_valid = 0; e_data = '0;
        end else begin
            e_rsp = pop; e_valid = 0; e_data = '0;
            if (pop && (m_wc != m_rc)) begin
                e_valid = 1; e_data = m_ring[m_rc]; m_rc = m_rc + 8'd1;
            end
            if (s_k2 && !s_k3) begin
                m_ring[m_wc] = d_k2; m_wc = m_wc + 8'd1;
            end
            s_k3 = s_k2; s_k2 = s_k1; s_k1 = strobe;
            d_k2 = d_k1; d_k1 = bus_data;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(avail_o == (m_wc != m_rc), "R3", "per-cycle avail", avail_o, m_wc != m_rc);
            check(rsp_o == e_rsp && rsp_valid_o == e_valid && rsp_data_o == e_data,
                  "R4", "per-cycle response", {rsp_o, rsp_valid_o, rsp_data_o},
                  {e_rsp, e_valid, e_data});
        end
    end

    // ---------------- target memory responder ----------------
    logic [7:0]    tmem [int];
    int            n_writes = 0, n_reads = 0, lat_cnt = 0;
    logic [AW-1:0] last_raddr = '0, h_addr = '0;
    logic          h_we = 0;
    logic [7:0]    h_data = '0;

    function automatic logic [7:0] tread(input int a);
        return tmem.exists(a) ? tmem[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 0; lat_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 0;
        end else if (mem_req_o) begin
            if (lat_cnt == 0) begin
                h_addr = mem_addr_o; h_we = mem_we_o; h_data = mem_wdata_o;
            end else begin
                check(h_addr == mem_addr_o && h_we == mem_we_o && h_data == mem_wdata_o,
                      "R9", "request held stable", mem_addr_o, h_addr);
            end
            if (lat_cnt == MEM_LAT) begin
                mem_ack = 1; lat_cnt = 0;
                if (mem_we_o) begin
                    tmem[int'(mem_addr_o)] = mem_wdata_o; n_writes++;
                end else begin
                    mem_rdata = tread(int'(mem_addr_o)); n_reads++; last_raddr = mem_addr_o;
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_byte(input logic [7:0] b, input int hold = 3);
        @(negedge clk); bus_data = b; strobe = 1;
        repeat (hold) @(negedge clk);
        strobe = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop_once();
        @(negedge clk); pop = 1;
        @(negedge clk); pop = 0;
    endtask

    task automatic load_base(input logic [AW-1:0] b);
        @(negedge clk); base_load = 1; base_addr = b;
        @(negedge clk); base_load = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int w0, r0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!avail_o && !rsp_o && !rsp_valid_o && !mem_req_o, "R1", "reset outputs",
              {avail_o, rsp_o, rsp_valid_o, mem_req_o}, 0);

        // R2 ordered capture
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        check(avail_o, "R2", "data after captures", avail_o, 1);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'h11, "R2", "first byte", rsp_data_o, 8'h11);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'h22, "R2", "second byte", rsp_data_o, 8'h22);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'h33, "R2", "third byte", rsp_data_o, 8'h33);
        // R4 empty pop
        pop_once();
        check(rsp_o && !rsp_valid_o && rsp_data_o == 8'h00, "R4", "empty pop invalid",
              {rsp_o, rsp_valid_o, rsp_data_o}, 10'h200);
        check(!avail_o, "R4", "read position unchanged", avail_o, 0);

        // R11 long strobe captures once
        send_byte(8'h44, 20);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'h44, "R11", "long strobe byte", rsp_data_o, 8'h44);
        pop_once(); check(!rsp_valid_o, "R11", "no second capture", rsp_valid_o, 0);

        // R10 capture and pop on the same edge, empty store
        @(negedge clk); bus_data = 8'h55; strobe = 1;
        @(negedge clk);
        @(negedge clk); pop = 1;
        @(negedge clk); pop = 0;
        check(rsp_o && !rsp_valid_o, "R10", "same-edge pop sees empty", rsp_valid_o, 0);
        check(avail_o, "R10", "same-edge byte kept", avail_o, 1);
        strobe = 0; repeat (3) @(negedge clk);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'h55, "R10", "same-edge byte", rsp_data_o, 8'h55);
        // R10 with one byte waiting
        send_byte(8'h66);
        @(negedge clk); bus_data = 8'h77; strobe = 1;
        @(negedge clk);
        @(negedge clk); pop = 1;
        @(negedge clk); pop = 0;
        check(rsp_valid_o && rsp_data_o == 8'h66, "R10", "same-edge old byte", rsp_data_o, 8'h66);
        strobe = 0; repeat (3) @(negedge clk);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'h77, "R10", "same-edge new byte", rsp_data_o, 8'h77);

        // R7 no traffic without base
        check(n_writes == 0 && n_reads == 0, "R7", "no memory traffic", n_writes + n_reads, 0);

        // R8 remote start-up
        tmem[int'(BASE) - 2] = 8'h5A;
        load_base(BASE);
        repeat (20) @(negedge clk);
        check(n_reads == 1 && last_raddr == BASE - 16'd2, "R8", "producer index read", last_raddr, BASE - 16'd2);
        check(n_writes == 1 && tread(int'(BASE) - 1) == 8'h5A, "R8", "consumer index copied",
              tread(int'(BASE) - 1), 8'h5A);

        // R6 single report
        send_byte(8'h81);
        w0 = n_writes;
        pop_once();
        repeat (12) @(negedge clk);
        check(n_writes == w0 + 1, "R6", "one report per pop", n_writes - w0, 1);
        check(tread(int'(BASE) - 1) == m_rc, "R6", "reported position", tread(int'(BASE) - 1), m_rc);

        // R6 merged reports
        send_byte(8'h82); send_byte(8'h83); send_byte(8'h84);
        w0 = n_writes;
        @(negedge clk); pop = 1;
        repeat (3) @(negedge clk);
        pop = 0;
        repeat (20) @(negedge clk);
        check(n_writes == w0 + 2, "R6", "merged report count", n_writes - w0, 2);
        check(tread(int'(BASE) - 1) == m_rc, "R6", "merged latest position", tread(int'(BASE) - 1), m_rc);

        // R5 read position wraps to zero
        while (m_rc != 8'hFF) begin
            send_byte(m_wc ^ 8'hA5);
            pop_once();
        end
        send_byte(8'hE1);
        pop_once();
        repeat (12) @(negedge clk);
        check(m_rc == 8'h00 && tread(int'(BASE) - 1) == 8'h00, "R5", "wrapped position reported",
              tread(int'(BASE) - 1), 0);

        // R8 zero base disables, R7 then no traffic
        w0 = n_writes; r0 = n_reads;
        load_base('0);
        repeat (5) @(negedge clk);
        send_byte(8'h90);
        pop_once();
        repeat (12) @(negedge clk);
        check(n_writes == w0 && n_reads == r0, "R7", "no traffic after zero base",
              n_writes + n_reads - w0 - r0, 0);

        // R3 overflow without pop
        for (int i = 0; i < 256; i++) send_byte(8'(i));
        check(!avail_o, "R3", "store empty after full lap", avail_o, 0);
        send_byte(8'hC3);
        pop_once(); check(rsp_valid_o && rsp_data_o == 8'hC3, "R3", "overwritten slot", rsp_data_o, 8'hC3);

        repeat (4) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule